// File: doc/BRIEF.md
# Floating-Point Compare to Condition Field

This unit compares two IEEE-754 double-precision operands and turns the result into a 4-bit code. It writes that code into one chosen field of a 32-bit condition register made of eight 4-bit fields. It also writes the same code into a 4-bit result-class nibble. The unit also reports invalid-operation flag updates. One flag marks a signaling-NaN operand. The other marks an invalid ordered comparison. Each flag is a one-cycle pulse that the surrounding status logic ORs into its sticky bits.

A compare starts when `cmp_valid` is high at a rising clock edge. The unit registers all of its results at that edge. A small controller tracks the result slot and has two states. `ST_IDLE` means no fresh result is waiting. `ST_DONE` means the outputs hold the result of the compare strobed on the previous edge. The controller moves from either state to `ST_DONE` when `cmp_valid` is high, and from either state to `ST_IDLE` when `cmp_valid` is low. So a compare can be issued on every cycle.

Top module: `fpcmp_cond_unit`

## Requirements
- R1: After reset, `cond_reg`, `result_class`, `done`, `set_snan` and `set_vc` are all zero.
- R2: An operand is a NaN when its 11-bit exponent (bits 62:52) is all ones and its 52-bit fraction is non-zero. When either operand is a NaN, the code is 4'b0001 (the unordered bit alone).
- R3: When neither operand is a NaN, exactly one bit is set. The code is 4'b1000 when a < b, 4'b0100 when a > b and 4'b0010 when they are equal. The less-than test is made first, then greater-than, then equal.
- R4: Plus zero and minus zero compare equal, whatever the sign of either one.
- R5: Non-NaN operands, including both infinities, are ordered by sign and magnitude. Any negative value is below any positive value. Among negative values, the larger magnitude is the smaller value.
- R6: The code is written to the field selected by `field_sel`. Field k occupies bits 31-4k down to 28-4k, so field 0 is at bits 31:28. The other seven fields keep their values.
- R7: `result_class` takes the same code as the written field.
- R8: `set_snan` pulses when either operand is a signaling NaN, meaning a NaN whose fraction bit 51 is zero. This happens in both compare modes.
- R9: `set_vc` pulses only when `ordered_mode` is 1 and either operand is a NaN. It does not pulse when a signaling NaN is present while `inv_trap_en` is 1.
- R10: Results appear on the first rising edge at which `cmp_valid` is high, and `done` is high for the cycle that follows. A cycle with `cmp_valid` low leaves `cond_reg` and `result_class` unchanged, and in that cycle `done`, `set_snan` and `set_vc` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmp_valid | input | 1 | Starts a compare at this edge |
| opnd_a | input | 64 | First double-precision operand |
| opnd_b | input | 64 | Second double-precision operand |
| field_sel | input | 3 | Index of the condition field to write |
| ordered_mode | input | 1 | 1 selects ordered compare, 0 selects unordered |
| inv_trap_en | input | 1 | Invalid-operation traps are enabled |
| cond_reg | output | 32 | Condition register, eight 4-bit fields |
| result_class | output | 4 | Result-class nibble |
| done | output | 1 | A result was registered on the last edge |
| set_snan | output | 1 | Pulse: a signaling-NaN operand was seen |
| set_vc | output | 1 | Pulse: an invalid ordered compare occurred |

## Verification
The random operand mix covers several cases:
- **Unrelated bit patterns** exercise mixed signs and exponents.
- **Pairs that share an exponent, or that are identical** exercise the magnitude-only order and the equal code.
- **Zeros of both signs** confirm that the sign is ignored for zero.
- **Infinities** confirm that they sit at the ends of the order.
- **Quiet and signaling NaNs** are combined with both modes and both trap settings, which separates the unordered code from the two flag rules.

Expected codes come from a real-number compare in the bench. Each compare uses a random field index. After every compare, an idle cycle confirms that the other fields and the nibble are held.

// File: rtl/fpcmp_pkg.sv
package fpcmp_pkg;
    localparam int CODE_W = 4;
    typedef logic [CODE_W-1:0] code_t;

    // code bit order, most significant first: less, greater, equal, unordered
    localparam code_t CODE_LT = 4'b1000;
    localparam code_t CODE_GT = 4'b0100;
    localparam code_t CODE_EQ = 4'b0010;
    localparam code_t CODE_UN = 4'b0001;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_DONE = 1'b1
    } cmp_state_e;
endpackage

// File: rtl/fpcmp_classify.sv
module fpcmp_classify #(
    parameter int DATA_W = 64,
    parameter int EXP_W  = 11
) (
    input  logic [DATA_W-1:0] opnd,
    output logic              is_neg,
    output logic              is_nan,
    output logic              is_snan,
    output logic              is_zero
);
    localparam int FRAC_W = DATA_W - 1 - EXP_W;

    logic [EXP_W-1:0]  expo;
    logic [FRAC_W-1:0] frac;

    assign expo    = opnd[DATA_W-2 -: EXP_W];
    assign frac    = opnd[FRAC_W-1:0];
    assign is_neg  = opnd[DATA_W-1];
    assign is_nan  = (&expo) && (|frac);
    // quiet flag is the top fraction bit; a NaN without it is signaling
    assign is_snan = is_nan && !frac[FRAC_W-1];
    assign is_zero = ~|opnd[DATA_W-2:0];
endmodule

// File: rtl/fpcmp_order.sv
module fpcmp_order
    import fpcmp_pkg::*;
#(
    parameter int MAG_W = 63
) (
    input  logic [MAG_W-1:0] mag_a,
    input  logic [MAG_W-1:0] mag_b,
    input  logic             neg_a,
    input  logic             neg_b,
    input  logic             nan_any,
    input  logic             zero_both,
    output code_t            code
);
    logic mag_lt;
    assign mag_lt = mag_a < mag_b;

    always_comb begin
        if (nan_any) begin
            code = CODE_UN;
        end else if (zero_both) begin
            code = CODE_EQ;
        end else if (neg_a != neg_b) begin
            code = neg_a ? CODE_LT : CODE_GT;
        end else if (mag_a == mag_b) begin
            code = CODE_EQ;
        end else if (mag_lt ^ neg_a) begin
            code = CODE_LT;
        end else begin
            code = CODE_GT;
        end
    end
endmodule

// File: rtl/fpcmp_field_merge.sv
module fpcmp_field_merge #(
    parameter int NFIELD  = 8,
    parameter int FIELD_W = 4,
    parameter int SEL_W   = $clog2(NFIELD)
) (
    input  logic [NFIELD*FIELD_W-1:0] cr_in,
    input  logic [SEL_W-1:0]          sel,
    input  logic [FIELD_W-1:0]        code,
    output logic [NFIELD*FIELD_W-1:0] cr_out
);
    localparam int CR_W = NFIELD * FIELD_W;

    for (genvar k = 0; k < NFIELD; k++) begin : g_field
        localparam int HI = CR_W - 1 - k * FIELD_W;
        assign cr_out[HI -: FIELD_W] = (sel == SEL_W'(k)) ? code : cr_in[HI -: FIELD_W];
    end
endmodule

// File: rtl/fpcmp_cond_unit.sv
module fpcmp_cond_unit
    import fpcmp_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int EXP_W  = 11,
    parameter int NFIELD = 8,
    localparam int SEL_W = $clog2(NFIELD),
    localparam int CR_W  = NFIELD * CODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmp_valid,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic [SEL_W-1:0]  field_sel,
    input  logic              ordered_mode,
    input  logic              inv_trap_en,
    output logic [CR_W-1:0]   cond_reg,
    output code_t             result_class,
    output logic              done,
    output logic              set_snan,
    output logic              set_vc
);
    logic a_neg, a_nan, a_snan, a_zero;
    logic b_neg, b_nan, b_snan, b_zero;

    fpcmp_classify #(.DATA_W(DATA_W), .EXP_W(EXP_W)) u_cls_a (
        .opnd(opnd_a), .is_neg(a_neg), .is_nan(a_nan), .is_snan(a_snan), .is_zero(a_zero)
    );
    fpcmp_classify #(.DATA_W(DATA_W), .EXP_W(EXP_W)) u_cls_b (
        .opnd(opnd_b), .is_neg(b_neg), .is_nan(b_nan), .is_snan(b_snan), .is_zero(b_zero)
    );

    code_t cmp_code;
    fpcmp_order #(.MAG_W(DATA_W-1)) u_order (
        .mag_a(opnd_a[DATA_W-2:0]), .mag_b(opnd_b[DATA_W-2:0]),
        .neg_a(a_neg), .neg_b(b_neg),
        .nan_any(a_nan | b_nan), .zero_both(a_zero & b_zero),
        .code(cmp_code)
    );

    logic [CR_W-1:0] cr_next;
    fpcmp_field_merge #(.NFIELD(NFIELD), .FIELD_W(CODE_W), .SEL_W(SEL_W)) u_merge (
        .cr_in(cond_reg), .sel(field_sel), .code(cmp_code), .cr_out(cr_next)
    );

    logic snan_any, vc_hit;
    assign snan_any = a_snan | b_snan;
    assign vc_hit   = ordered_mode && (a_nan || b_nan) && !(snan_any && inv_trap_en);

    cmp_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = cmp_valid ? ST_DONE : ST_IDLE;
            ST_DONE: state_d = cmp_valid ? ST_DONE : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cond_reg     <= '0;
            result_class <= '0;
            set_snan     <= 1'b0;
            set_vc       <= 1'b0;
        end else begin
            set_snan <= cmp_valid && snan_any;
            set_vc   <= cmp_valid && vc_hit;
            if (cmp_valid) begin
                cond_reg     <= cr_next;
                result_class <= cmp_code;
            end
        end
    end

    assign done = (state_q == ST_DONE);

    // R10
    done_follows_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_valid |=> done);

    // R10
    idle_holds_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp_valid |=> ($stable(cond_reg) && $stable(result_class) && !done && !set_vc && !set_snan));

    // R3
    single_code_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($countones(result_class) == 1));

    // R7
    class_mirrors_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_valid |=> (cond_reg[(NFIELD-1-int'($past(field_sel)))*CODE_W +: CODE_W] == result_class));

    // R9
    vc_needs_ordered_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid && !ordered_mode) |=> !set_vc);

    // R2
    flags_imply_unordered_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_snan || set_vc) |-> (result_class == CODE_UN));
endmodule

// File: tb/fpcmp_cond_unit_tb.sv
`timescale 1ns/1ps
module fpcmp_cond_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmp_valid = 1'b0;
    logic [63:0] opnd_a = '0, opnd_b = '0;
    logic [2:0]  field_sel = '0;
    logic        ordered_mode = 1'b0, inv_trap_en = 1'b0;
    logic [31:0] cond_reg;
    logic [3:0]  result_class;
    logic        done, set_snan, set_vc;

    int n_cmp = 0, n_bad = 0;
    logic [31:0] model_cr = '0;

    always #4 clk = ~clk;

    fpcmp_cond_unit u_dut (
        .clk(clk), .rst_n(rst_n), .cmp_valid(cmp_valid), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .field_sel(field_sel), .ordered_mode(ordered_mode), .inv_trap_en(inv_trap_en),
        .cond_reg(cond_reg), .result_class(result_class), .done(done),
        .set_snan(set_snan), .set_vc(set_vc)
    );

    localparam logic [63:0] P_ZERO = 64'h0000_0000_0000_0000;
    localparam logic [63:0] N_ZERO = 64'h8000_0000_0000_0000;
    localparam logic [63:0] P_INF  = 64'h7FF0_0000_0000_0000;
    localparam logic [63:0] N_INF  = 64'hFFF0_0000_0000_0000;
    localparam logic [63:0] P_MAX  = 64'h7FEF_FFFF_FFFF_FFFF;
    localparam logic [63:0] QNAN   = 64'h7FF8_0000_0000_0001;
    localparam logic [63:0] SNAN   = 64'hFFF0_0000_0000_0005;
    localparam logic [63:0] ONE    = 64'h3FF0_0000_0000_0000;
    localparam logic [63:0] M_TWO  = 64'hC000_0000_0000_0000;
    localparam logic [63:0] M_ONE  = 64'hBFF0_0000_0000_0000;

    function automatic bit m_nan(input logic [63:0] v);
        return (v[62:52] == 11'h7FF) && (v[51:0] != 0);
    endfunction
    function automatic bit m_snan(input logic [63:0] v);
        return m_nan(v) && !v[51];
    endfunction
    function automatic logic [3:0] m_code(input logic [63:0] a, input logic [63:0] b);
        real ra, rb;
        if (m_nan(a) || m_nan(b)) return 4'b0001;
        ra = $bitstoreal(a);
        rb = $bitstoreal(b);
        if (ra < rb) return 4'b1000;
        if (ra > rb) return 4'b0100;
        return 4'b0010;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_cmp(input logic [63:0] a, input logic [63:0] b, input logic [2:0] sel,
                           input logic ord, input logic trap, input string tag);
        logic [3:0] c;
        logic [31:0] prev;
        c = m_code(a, b);
        @(negedge clk);
        opnd_a = a; opnd_b = b; field_sel = sel; ordered_mode = ord; inv_trap_en = trap;
        cmp_valid = 1'b1;
        @(negedge clk);
        cmp_valid = 1'b0;
        model_cr[31 - 4*sel -: 4] = c;
        check({tag, " R6 cond_reg"}, cond_reg, model_cr);
        check({tag, " R7 result_class"}, {28'd0, result_class}, {28'd0, c});
        check({tag, " R8 set_snan"}, {31'd0, set_snan}, {31'd0, m_snan(a) || m_snan(b)});
        check({tag, " R9 set_vc"}, {31'd0, set_vc},
              {31'd0, ord && (m_nan(a) || m_nan(b)) && !((m_snan(a) || m_snan(b)) && trap)});
        check({tag, " R10 done"}, {31'd0, done}, 32'd1);
        prev = cond_reg;
        @(negedge clk);
        check({tag, " R10 idle hold"}, cond_reg, prev);
        check({tag, " R10 idle done"}, {29'd0, done, set_snan, set_vc}, 32'd0);
    endtask

    function automatic logic [63:0] gen_op(input logic [63:0] other);
        logic [63:0] v;
        v = {$urandom, $urandom};
        case ($urandom % 8)
            0: v = other;
            1: v[62:52] = other[62:52];
            2: v = {v[63], 63'd0};
            3: v = {v[63], 11'h7FF, 52'd0};
            4: begin v[62:52] = 11'h7FF; v[51] = 1'b1; end
            5: begin v[62:52] = 11'h7FF; v[51] = 1'b0; if (v[50:0] == 0) v[0] = 1'b1; end
            default: ;
        endcase
        return v;
    endfunction

    task automatic summary;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        summary();
    end

    initial begin
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        check("R1 cond_reg reset", cond_reg, 32'd0);
        check("R1 flags reset", {25'd0, result_class, done, set_snan, set_vc}, 32'd0);
        rst_n = 1'b1;
        // directed corners
        run_cmp(P_ZERO, N_ZERO, 3'd0, 1'b1, 1'b0, "R4 +0 vs -0");
        run_cmp(N_ZERO, P_ZERO, 3'd7, 1'b0, 1'b0, "R4 -0 vs +0");
        run_cmp(N_INF, P_INF, 3'd1, 1'b0, 1'b0, "R5 -inf < +inf");
        run_cmp(P_INF, P_MAX, 3'd2, 1'b0, 1'b0, "R5 +inf > max");
        run_cmp(M_TWO, M_ONE, 3'd3, 1'b0, 1'b0, "R5 negative magnitudes");
        run_cmp(M_ONE, ONE, 3'd4, 1'b0, 1'b0, "R5 sign order");
        run_cmp(ONE, ONE, 3'd5, 1'b0, 1'b0, "R3 equal");
        run_cmp(QNAN, ONE, 3'd6, 1'b0, 1'b0, "R2 qnan unordered");
        run_cmp(ONE, QNAN, 3'd6, 1'b1, 1'b1, "R9 qnan ordered");
        run_cmp(SNAN, ONE, 3'd0, 1'b1, 1'b0, "R8 snan ordered");
        run_cmp(ONE, SNAN, 3'd1, 1'b1, 1'b1, "R9 snan trap");
        run_cmp(SNAN, QNAN, 3'd2, 1'b0, 1'b1, "R8 snan unordered");
        for (int i = 0; i < 600; i++) begin
            logic [63:0] a, b;
            a = gen_op({$urandom, $urandom});
            b = gen_op(a);
            if ($urandom % 2) begin logic [63:0] t; t = a; a = b; b = t; end
            run_cmp(a, b, 3'($urandom), 1'($urandom), 1'($urandom), "R3 R5 random");
        end
        summary();
    end
endmodule